// File: doc/BRIEF.md
# Wraparound Self-Test Checker

This block runs a continuous built-in test alongside normal traffic on a dual-channel serial data bus terminal. At the end of every message the final word handed to the encoder is latched as the expected value. The same word, echoed back through the receiver of the currently active channel, is then compared with it in full: all data bits, the word type (command/status sync versus data sync) and a clean decode. If the echo differs, or does not arrive in time, a sticky loop-test error flag is raised.

A second check runs when the unit acts as bus controller. Each status word that comes back from a remote terminal has its address field compared with the expected terminal address, and a sticky status-error flag is raised on a mismatch. The subsystem can also start a loop test on demand by pulsing a start input together with a test word. Both flags stay set until the next start-of-message pulse or a reset.

Top module: `wrap_bit_chk`

## Requirements
- R1: After reset both error flags are low and no comparison is pending.
- R2: A comparison is armed only by a transmit strobe with the last-word marker set; transmit strobes without the marker neither arm nor change the expected word.
- R3: Only a received word on the channel equal to `active_ch` is taken as the looped word; words received on the other channel are ignored.
- R4: The looped word passes only if its 16 data bits and its type bit equal the expected ones and `rx_err` is low; any difference sets `loop_err` one clock after the receive strobe.
- R5: The looped word is accepted when its strobe falls on clock edges 1 to 32 after the arming edge; if none arrives, `loop_err` sets on edge 32 and a later strobe is not compared.
- R6: With `bc_mode` high, a received word with `rx_stat` high on the active channel whose bits [15:11] differ from `exp_addr` sets `stat_err` one clock later; a matching address leaves it clear.
- R7: With `bc_mode` low, status words are not address-checked and `stat_err` stays low.
- R8: Both flags hold once set and are cleared by a `som` pulse; an error detected in the same cycle as `som` still sets its flag.
- R9: A `loop_start` pulse arms a comparison with `tx_word` and `tx_type`, exactly as an end-of-message word does.
- R10: Only the first active-channel word after arming is compared; later words do not affect `loop_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| som | input | 1 | Start-of-message pulse, clears the flags |
| bc_mode | input | 1 | High when operating as bus controller |
| active_ch | input | 1 | Channel currently in use (0 or 1) |
| exp_addr | input | 5 | Expected remote terminal address |
| tx_valid | input | 1 | Transmit word strobe |
| tx_last | input | 1 | Marks the final word of the message |
| tx_word | input | 16 | Transmitted word data |
| tx_type | input | 1 | Transmitted word type, 1 = command/status sync |
| loop_start | input | 1 | Subsystem request to arm a loop test |
| rx_valid | input | 1 | Received word strobe |
| rx_ch | input | 1 | Channel the word was received on |
| rx_word | input | 16 | Received word data |
| rx_type | input | 1 | Received word type, 1 = command/status sync |
| rx_err | input | 1 | Decoder reported a parity, Manchester or bit-count error |
| rx_stat | input | 1 | Received word is a status response |
| loop_err | output | 1 | Sticky loop-test error |
| stat_err | output | 1 | Sticky status address error |

## Verification
The bench flips each data bit, the type bit and the decode error of the echoed word in turn; a comparator that drops a bit or ignores the type or error would leave the flag clear. It sweeps the echo delay from 1 to 33 edges so that an off-by-one window either flags a legal echo at edge 32 or misses the timeout. All 32 status addresses are tried against a fixed expected address, and words on the idle channel, non-final transmit words and second echoes are injected where a design that does not filter them would corrupt the result.

// File: rtl/wrap_bit_chk.sv
module wrap_bit_chk #(
  parameter int DW      = 16,
  parameter int AW      = 5,
  parameter int TIMEOUT = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          som,
  input  logic          bc_mode,
  input  logic          active_ch,
  input  logic [AW-1:0] exp_addr,
  input  logic          tx_valid,
  input  logic          tx_last,
  input  logic [DW-1:0] tx_word,
  input  logic          tx_type,
  input  logic          loop_start,
  input  logic          rx_valid,
  input  logic          rx_ch,
  input  logic [DW-1:0] rx_word,
  input  logic          rx_type,
  input  logic          rx_err,
  input  logic          rx_stat,
  output logic          loop_err,
  output logic          stat_err
);
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [DW-1:0] exp_w;
  logic          exp_t;
  logic          pend;
  logic [CW-1:0] cnt;

  wire arm      = (tx_valid & tx_last) | loop_start;
  wire hit      = rx_valid & (rx_ch == active_ch);
  wire miss     = (rx_word != exp_w) | (rx_type != exp_t) | rx_err;
  wire expire   = pend & ~hit & (cnt == LAST);
  wire stat_bad = bc_mode & hit & rx_stat & (rx_word[DW-1 -: AW] != exp_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      cnt      <= '0;
      exp_w    <= '0;
      exp_t    <= 1'b0;
      loop_err <= 1'b0;
      stat_err <= 1'b0;
    end else begin
      if (som) begin
        loop_err <= 1'b0;
        stat_err <= 1'b0;
      end
      if (stat_bad) stat_err <= 1'b1;
      if (arm) begin
        pend  <= 1'b1;
        cnt   <= '0;
        exp_w <= tx_word;
        exp_t <= tx_type;
      end else if (pend) begin
        if (hit) begin
          pend <= 1'b0;
          if (miss) loop_err <= 1'b1;
        end else if (expire) begin
          pend     <= 1'b0;
          loop_err <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wrap_bit_chk_sva.sv
module wrap_bit_chk_sva (
  input logic clk,
  input logic rst_n,
  input logic som,
  input logic bc_mode,
  input logic rx_valid,
  input logic rx_stat,
  input logic pend,
  input logic expire,
  input logic loop_err,
  input logic stat_err
);
  assert_loop_needs_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_err) |-> $past(pend));

  assert_stat_only_in_bc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_err) |-> $past(bc_mode && rx_valid && rx_stat));

  assert_loop_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_err && !som) |=> loop_err);

  assert_stat_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_err && !som) |=> stat_err);

  assert_som_clears_stat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (som && !rx_valid) |=> !stat_err);

  assert_som_clears_loop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (som && !rx_valid && !expire) |=> !loop_err);
endmodule

bind wrap_bit_chk wrap_bit_chk_sva i_sva (
  .clk(clk), .rst_n(rst_n), .som(som), .bc_mode(bc_mode),
  .rx_valid(rx_valid), .rx_stat(rx_stat), .pend(pend), .expire(expire),
  .loop_err(loop_err), .stat_err(stat_err)
);

// File: tb/test_wrap_bit_chk.sv
`timescale 1ns/1ps
module test_wrap_bit_chk;
  logic clk = 0, rst_n = 0;
  logic som = 0, bc_mode = 0, active_ch = 0;
  logic [4:0] exp_addr = 5'h0B;
  logic tx_valid = 0, tx_last = 0, tx_type = 0, loop_start = 0;
  logic [15:0] tx_word = 0, rx_word = 0;
  logic rx_valid = 0, rx_ch = 0, rx_type = 0, rx_err = 0, rx_stat = 0;
  logic loop_err, stat_err;
  int checks = 0, fails = 0;
  bit done = 0;
  localparam logic [15:0] BASE = 16'hA5C3;

  always #2 clk = ~clk;

  wrap_bit_chk i_wrap_bit_chk (.*);

  task automatic step();
    @(posedge clk); @(negedge clk);
    som = 0; tx_valid = 0; tx_last = 0; loop_start = 0;
    rx_valid = 0; rx_err = 0; rx_stat = 0;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic clear(); som = 1; step(); endtask

  task automatic send_last(input logic [15:0] w, input logic t);
    tx_word = w; tx_type = t; tx_valid = 1; tx_last = 1; step();
  endtask

  task automatic rx(input logic [15:0] w, input logic t, input logic e,
                    input logic ch, input logic st);
    rx_word = w; rx_type = t; rx_err = e; rx_ch = ch; rx_stat = st;
    rx_valid = 1; step();
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog: got hang expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); step(); step();
    chk(loop_err, 0, "R1 loop_err after reset");
    chk(stat_err, 0, "R1 stat_err after reset");
    rst_n = 1; step();
    repeat (40) step();
    chk(loop_err, 0, "R1 no pending check after reset");

    // R4: every field of the echo
    for (int k = 0; k <= 18; k++) begin
      clear();
      send_last(BASE, 1'b0);
      step(); step();
      rx((k < 16) ? BASE ^ (16'h1 << k) : BASE, k == 16, k == 17, 1'b0, 1'b0);
      chk(loop_err, k != 18, $sformatf("R4 field %0d", k));
    end

    // R5: echo delay window
    for (int d = 1; d <= 33; d++) begin
      clear();
      send_last(BASE, 1'b1);
      repeat (d - 1) step();
      if (d == 33) chk(loop_err, 1, "R5 timeout raised at edge 32");
      rx(BASE, 1'b1, 1'b0, 1'b0, 1'b0);
      chk(loop_err, d > 32, $sformatf("R5 delay %0d", d));
    end

    // R3: idle channel ignored
    active_ch = 1;
    clear();
    send_last(16'h1234, 1'b0);
    rx(16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b0);
    chk(loop_err, 0, "R3 idle-channel word ignored");
    rx(16'h1234, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(loop_err, 0, "R3 active-channel echo matches");
    active_ch = 0;

    // R2: non-final words neither arm nor overwrite
    clear();
    tx_word = 16'h0F0F; tx_valid = 1; step();
    repeat (40) step();
    chk(loop_err, 0, "R2 non-final word does not arm");
    send_last(16'h3C3C, 1'b0);
    tx_word = 16'h0001; tx_type = 1; tx_valid = 1; step();
    rx(16'h3C3C, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(loop_err, 0, "R2 non-final word keeps expected");

    // R10: only the first echo counts
    clear();
    send_last(16'h5555, 1'b0);
    rx(16'h5555, 1'b0, 1'b0, 1'b0, 1'b0);
    rx(16'hAAAA, 1'b1, 1'b1, 1'b0, 1'b0);
    chk(loop_err, 0, "R10 second word not compared");

    // R9: on-demand loop test
    clear();
    tx_word = 16'h7E81; tx_type = 0; loop_start = 1; step();
    rx(16'h7E81, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(loop_err, 0, "R9 demand loop pass");
    tx_word = 16'h7E81; loop_start = 1; step();
    rx(16'h7E80, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(loop_err, 1, "R9 demand loop mismatch");

    // R8: sticky, cleared by som
    repeat (5) step();
    chk(loop_err, 1, "R8 loop_err holds");
    clear();
    chk(loop_err, 0, "R8 som clears loop_err");

    // R6: status address sweep
    bc_mode = 1;
    for (int a = 0; a < 32; a++) begin
      clear();
      rx({a[4:0], 11'h2A5}, 1'b1, 1'b0, 1'b0, 1'b1);
      chk(stat_err, a != 11, $sformatf("R6 address %0d", a));
      chk(loop_err, 0, "R6 status leaves loop_err");
    end
    rx(16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b1);
    repeat (3) step();
    chk(stat_err, 1, "R8 stat_err holds");
    som = 1; rx(16'h0000, 1'b1, 1'b0, 1'b0, 1'b1);
    chk(stat_err, 1, "R8 error with som still sets");
    clear();
    chk(stat_err, 0, "R8 som clears stat_err");

    // R7: no address check outside controller mode
    bc_mode = 0;
    rx(16'h0000, 1'b1, 1'b0, 1'b0, 1'b1);
    chk(stat_err, 0, "R7 no check in terminal mode");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule